// File: doc/BRIEF.md
# Integer Compare Flag Generator

This block compares two integer operands and reports the relation between them as a set of six arithmetic status flags. It subtracts the second operand from the first and keeps only the flags. The difference itself is never output, and neither operand is changed. The operand width is chosen per request from 8, 16, 32 or 64 bits. Both operands always share that width, and operand bits above it are ignored.

A request is a single-cycle `in_valid` strobe with both operands and the size code. One clock edge later the flag vector is registered on `flags_o` and `done_o` is high. The flags then hold until the next request.

A small control state machine sequences the handshake. It has two states:
- `ST_IDLE`: no result is pending.
- `ST_DONE`: a result was captured on the last edge.

Its transitions are:
- `IDLE->DONE` on a strobe.
- `DONE->DONE` on a back-to-back strobe.
- `DONE->IDLE` when no strobe arrives.

Top module: `intcmp_flags`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `flags_o` is 0 and `done_o` is 0.
- R2: A strobe on `in_valid` captured at a clock edge makes `done_o` high for the following cycle. `done_o` stays high while strobes continue on consecutive cycles, and it falls one cycle after the last strobe.
- R3: Flag vector layout: bit 0 CF, bit 1 ZF, bit 2 SF, bit 3 OF, bit 4 AF, bit 5 PF. Read as unsigned, first > second gives CF=0 ZF=0, equal gives CF=0 ZF=1, and less gives CF=1 ZF=0.
- R4: Read as signed, first > second gives OF==SF with ZF=0, equal gives ZF=1, and less gives OF!=SF with ZF=0.
- R5: SF is the top bit of the difference at the selected width. OF is 1 exactly when the operand signs differ and the result sign differs from the first operand's sign.
- R6: AF is 1 exactly when the low nibble of the first operand is below the low nibble of the second, which is a borrow out of bit 3.
- R7: PF is 1 exactly when the low 8 bits of the difference hold an even number of ones.
- R8: Size code `size_sel` uses 0=8, 1=16, 2=32 and 3=64 bits. Operand bits at or above the selected width have no effect on any flag.
- R9: In a cycle without a strobe, `flags_o` keeps its previous value whatever the operand and size inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Request strobe |
| size_sel | input | 2 | Operand width code |
| opnd_a | input | 64 | First operand (minuend) |
| opnd_b | input | 64 | Second operand (subtrahend) |
| flags_o | output | 6 | Registered flag vector |
| done_o | output | 1 | Result-ready pulse |

## Verification
Every result is due exactly one clock edge after its strobe: `flags_o` and `done_o` both come from registers loaded at that edge. The bench drives each request on a falling edge and lifts the strobe at the next falling edge. It compares flags and done at that point, half a cycle after the capturing edge. One further cycle later it samples again, to see `done_o` fall and the flags hold. Expected flags come from a model in the bench that uses plain unsigned and sign-extended arithmetic. That model shares nothing with the borrow logic in the design.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
    localparam int FLAG_W = 6;
    localparam int FB_CF  = 0;
    localparam int FB_ZF  = 1;
    localparam int FB_SF  = 2;
    localparam int FB_OF  = 3;
    localparam int FB_AF  = 4;
    localparam int FB_PF  = 5;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/cmpf_lane.sv
module cmpf_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         cf,
    output logic         zf,
    output logic         sf,
    output logic         of
);
    logic [W:0] diff;

    always_comb begin
        diff = {1'b0, a} - {1'b0, b};
        cf   = diff[W];
        zf   = (diff[W-1:0] == '0);
        sf   = diff[W-1];
        of   = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);
    end
endmodule

// File: rtl/cmpf_core.sv
module cmpf_core
    import cmpf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANES  = 4
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        size_sel,
    output logic [FLAG_W-1:0] flags_nxt
);
    localparam int SEL_W = $clog2(LANES);

    logic [LANES-1:0] l_cf, l_zf, l_sf, l_of;
    logic [4:0]       nib_diff;
    logic [7:0]       low_byte;
    logic [SEL_W-1:0] sel;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            localparam int LW = 8 << i;
            cmpf_lane #(.W(LW)) u_lane (
                .a  (opa[LW-1:0]),
                .b  (opb[LW-1:0]),
                .cf (l_cf[i]),
                .zf (l_zf[i]),
                .sf (l_sf[i]),
                .of (l_of[i])
            );
        end
    endgenerate

    always_comb begin
        sel       = size_sel[SEL_W-1:0];
        nib_diff  = {1'b0, opa[3:0]} - {1'b0, opb[3:0]};
        low_byte  = opa[7:0] - opb[7:0];
        flags_nxt = '0;
        flags_nxt[FB_CF] = l_cf[sel];
        flags_nxt[FB_ZF] = l_zf[sel];
        flags_nxt[FB_SF] = l_sf[sel];
        flags_nxt[FB_OF] = l_of[sel];
        flags_nxt[FB_AF] = nib_diff[4];
        flags_nxt[FB_PF] = ~(^low_byte);
    end

    // R3: an equal result can never also borrow
    always_comb begin
        if (flags_nxt[FB_ZF]) a_zf_no_cf_r3: assert (!flags_nxt[FB_CF]);
    end
endmodule

// File: rtl/cmpf_ctrl.sv
module cmpf_ctrl
    import cmpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic capture,
    output logic done
);
    ctrl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_DONE;
            ST_DONE: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture = in_valid;
        done    = (state_q == ST_DONE);
    end

    p_done_follows_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);
    p_done_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid));
endmodule

// File: rtl/intcmp_flags.sv
module intcmp_flags
    import cmpf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        size_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [FLAG_W-1:0] flags_o,
    output logic              done_o
);
    logic [FLAG_W-1:0] flags_nxt;
    logic [FLAG_W-1:0] flags_q;
    logic              capture;
    logic              done;

    cmpf_core #(.DATA_W(DATA_W), .LANES(LANES)) u_core (
        .opa       (opnd_a),
        .opb       (opnd_b),
        .size_sel  (size_sel),
        .flags_nxt (flags_nxt)
    );

    cmpf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .capture  (capture),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       flags_q <= '0;
        else if (capture) flags_q <= flags_nxt;
    end

    always_comb begin
        flags_o = flags_q;
        done_o  = done;
    end

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(flags_o));
    p_zf_clears_sf_of_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FB_ZF] |-> !flags_o[FB_SF] && !flags_o[FB_OF]);
    p_zf_clears_cf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FB_ZF] |-> !flags_o[FB_CF]);
endmodule

// File: tb/intcmp_flags_tb_top.sv
`timescale 1ns/1ps
module intcmp_flags_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  size_sel;
    logic [63:0] opnd_a, opnd_b;
    logic [5:0]  flags_o;
    logic        done_o;
    int n_checks = 0;
    int n_errs   = 0;

    always #2.5 clk = ~clk;

    intcmp_flags dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .flags_o(flags_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [5:0] model(input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b);
        int w;
        logic [63:0] mask, ua, ub, d;
        logic signed [65:0] sa, sb, sd, smax;
        logic [5:0] f;
        w    = 8 << sz;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
        ua = a & mask; ub = b & mask;
        d  = (ua - ub) & mask;
        sa = {2'b00, ua}; sb = {2'b00, ub};
        if (ua[w-1]) sa = sa - (66'sd1 <<< w);
        if (ub[w-1]) sb = sb - (66'sd1 <<< w);
        sd   = sa - sb;
        smax = (66'sd1 <<< (w-1)) - 66'sd1;
        f[0] = (ua < ub);
        f[1] = (ua == ub);
        f[2] = d[w-1];
        f[3] = (sd > smax) || (sd < -smax - 66'sd1);
        f[4] = (ua[3:0] < ub[3:0]);
        f[5] = ~(^d[7:0]);
        return f;
    endfunction

    // one request; checks flags and done half a cycle after the capture edge
    task automatic cmp(input string req, input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; size_sel = sz; opnd_a = a; opnd_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " flags"}, {58'd0, flags_o}, {58'd0, model(sz, a, b)});
        chk("R2 done high", {63'd0, done_o}, 64'd1);
    endtask

    task automatic t_reset;
        chk("R1 flags reset", {58'd0, flags_o}, 64'd0);
        chk("R1 done reset", {63'd0, done_o}, 64'd0);
    endtask

    task automatic t_unsigned;
        cmp("R3 gt8", 2'd0, 64'h90, 64'h10);
        chk("R3 gt CF/ZF", {62'd0, flags_o[1:0]}, 64'd0);
        cmp("R3 eq16", 2'd1, 64'h1234, 64'h1234);
        chk("R3 eq CF/ZF", {62'd0, flags_o[1:0]}, 64'd2);
        cmp("R3 lt32", 2'd2, 64'h1, 64'hFFFF_FFFF);
        chk("R3 lt CF/ZF", {62'd0, flags_o[1:0]}, 64'd1);
        cmp("R3 lt64", 2'd3, 64'h0, 64'h1);
        chk("R3 lt64 CF", {63'd0, flags_o[0]}, 64'd1);
    endtask

    task automatic t_signed;
        cmp("R4 gt8", 2'd0, 64'h05, 64'hFB);
        chk("R4 gt OF==SF", {63'd0, flags_o[3] ^ flags_o[2]}, 64'd0);
        cmp("R4 lt16", 2'd1, 64'h8000, 64'h0001);
        chk("R4 lt OF!=SF", {63'd0, flags_o[3] ^ flags_o[2]}, 64'd1);
        cmp("R5 ovf32", 2'd2, 64'h7FFF_FFFF, 64'hFFFF_FFFF);
        chk("R5 OF set", {63'd0, flags_o[3]}, 64'd1);
        cmp("R5 ovf64", 2'd3, 64'h8000_0000_0000_0000, 64'h1);
        chk("R5 OF64 set", {63'd0, flags_o[3]}, 64'd1);
        cmp("R5 sf64", 2'd3, 64'h0, 64'h2);
        chk("R5 SF64 set", {63'd0, flags_o[2]}, 64'd1);
    endtask

    task automatic t_aux;
        cmp("R6 borrow", 2'd0, 64'h10, 64'h01);
        chk("R6 AF set", {63'd0, flags_o[4]}, 64'd1);
        cmp("R6 noborrow", 2'd1, 64'h0F, 64'h0F);
        chk("R6 AF clear", {63'd0, flags_o[4]}, 64'd0);
    endtask

    task automatic t_parity;
        cmp("R7 odd", 2'd2, 64'h07, 64'h00);
        chk("R7 PF clear", {63'd0, flags_o[5]}, 64'd0);
        cmp("R7 even", 2'd3, 64'h103, 64'h100);
        chk("R7 PF set", {63'd0, flags_o[5]}, 64'd1);
    endtask

    task automatic t_upper;
        cmp("R8 hi8", 2'd0, 64'hFFFF_FF05, 64'h0000_0005);
        chk("R8 hi8 eq", {58'd0, flags_o}, 64'h22);
        cmp("R8 hi16", 2'd1, 64'hAAAA_0000_0000_8000, 64'h5555_0000_0000_7FFF);
        cmp("R8 hi32", 2'd2, 64'h1_0000_0000, 64'h2_0000_0000);
        chk("R8 hi32 eq", {63'd0, flags_o[1]}, 64'd1);
    endtask

    task automatic t_hold;
        logic [5:0] prev;
        cmp("R9 setup", 2'd0, 64'h00, 64'h01);
        prev = flags_o;
        opnd_a = 64'h55; opnd_b = 64'h55; size_sel = 2'd3;
        @(negedge clk);
        chk("R2 done falls", {63'd0, done_o}, 64'd0);
        chk("R9 flags held", {58'd0, flags_o}, {58'd0, prev});
        @(negedge clk);
        chk("R9 flags held 2", {58'd0, flags_o}, {58'd0, prev});
    endtask

    task automatic t_b2b;
        @(negedge clk);
        in_valid = 1'b1; size_sel = 2'd0; opnd_a = 64'h3; opnd_b = 64'h3;
        @(negedge clk);
        chk("R2 b2b done1", {63'd0, done_o}, 64'd1);
        opnd_a = 64'h1; opnd_b = 64'h2;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 b2b done2", {63'd0, done_o}, 64'd1);
        chk("R2 b2b flags", {58'd0, flags_o}, {58'd0, model(2'd0, 64'h1, 64'h2)});
        @(negedge clk);
        chk("R2 b2b done fall", {63'd0, done_o}, 64'd0);
    endtask

    initial begin
        #100000;
        n_errs++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; size_sel = 2'd0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_aux();
        t_parity();
        t_upper();
        t_hold();
        t_b2b();
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule